// File: doc/BRIEF.md
# Receive Frame-Sync Generator

This block produces and watches the frame-sync line on the receive side of a synchronous serial port. It runs on the receive bit clock. A start-of-transfer strobe opens a sync window that is a programmable number of clock periods long. A 3-bit mode picks how the window, the transfer-active level or a per-transfer toggle shapes the sync pin. The mode also sets whether the block drives the pin at all.

During the same window the block shifts the serial data bit into a sync-data word. When the window closes it can compare the captured bits against two programmable patterns. An edge monitor watches the sync line, which is the internal value when the driver is on and the pin input otherwise. It sets a sticky flag on the edge polarity that software selects.

Top module: `rx_fsync_gen`

## Requirements
- R1: The window length is L+1 clock periods, where L = {len_hi_i, len_lo_i} and len_hi_i forms bits 7:4. The window covers the L+1 cycles that start in the cycle after start_i is sampled high.
- R2: With mode_i = 1, fs_oe_o is 1 and fs_o is 0 during the window and 1 outside it.
- R3: With mode_i = 2, fs_oe_o is 1 and fs_o is 1 during the window and 0 outside it.
- R4: With mode_i = 3, fs_o equals the inverse of xfer_active_i in the same cycle. With mode_i = 4, fs_o equals xfer_active_i. fs_oe_o is 1 in both modes.
- R5: With mode_i = 5, fs_o inverts in the cycle after each sampled start_i and holds its value otherwise.
- R6: With mode_i = 0, 6 or 7, fs_oe_o and fs_o are both 0.
- R7: The monitored sync line is fs_o when fs_oe_o is 1 and fs_pin_i otherwise. With edge_sel_i = 0, a rise of this line sets sync_det_o in the next cycle. With edge_sel_i = 1, a fall sets it. Nothing is detected in the first cycle after reset.
- R8: sync_det_o is sticky. A flag_clr_i pulse clears it in the next cycle. An edge in the same cycle as flag_clr_i leaves the flag set.
- R9: sd_i is sampled once per window cycle and shifted in MSB first. In the cycle after the last window cycle, sync_data_o shows the last min(L+1,16) bits, right-aligned, with all higher bits 0.
- R10: In the cycle sync_data_o updates, match_o pulses high for one cycle when cmp_en_i is 1 and the low min(L+1,16) bits match the same bits of cmp_pat0_i or of cmp_pat1_i. match_o is 0 at all other times.
- R11: A start_i that arrives during a window restarts the count. The window then ends L+1 cycles after the latest start, and bits shifted in before that start are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start-of-transfer strobe |
| xfer_active_i | input | 1 | Transfer-active level |
| mode_i | input | 3 | Sync output shape select |
| len_hi_i | input | 4 | Upper half of the length value |
| len_lo_i | input | 4 | Lower half of the length value |
| edge_sel_i | input | 1 | 0: rising edge sets the flag, 1: falling edge |
| flag_clr_i | input | 1 | Clear strobe for sync_det_o |
| sd_i | input | 1 | Serial data bit |
| fs_pin_i | input | 1 | Sync pin input value |
| cmp_en_i | input | 1 | Enable pattern comparison |
| cmp_pat0_i | input | 16 | Compare pattern 0 |
| cmp_pat1_i | input | 16 | Compare pattern 1 |
| fs_o | output | 1 | Sync pin drive value |
| fs_oe_o | output | 1 | Sync pin output enable |
| sync_det_o | output | 1 | Sticky sync-edge flag |
| sync_data_o | output | 16 | Captured sync data |
| match_o | output | 1 | One-cycle compare-match pulse |

## Verification
If start_i is sampled at the end of cycle s, the pulse shapes show the window from cycle s+1 through s+L+1. The sync flag for the leading edge appears in s+2, and sync_data_o and match_o are due in s+L+2. The level and disabled modes act on fs_o in the same cycle, and the toggle mode acts one cycle after the strobe. The bench drives inputs on the falling edge and checks outputs at the falling edge that starts each cycle, before driving the next inputs. It indexes every check by its offset from the start cycle. The level modes are checked a short delay after xfer_active_i changes.

// File: rtl/rx_fsync_pkg.sv
package rx_fsync_pkg;
  localparam int unsigned LEN_HALF_W = 4;
  localparam int unsigned LEN_W      = 2 * LEN_HALF_W;
  localparam int unsigned SD_W       = 16;

  typedef enum logic [2:0] {
    FS_OFF      = 3'd0,
    FS_NEG      = 3'd1,
    FS_POS      = 3'd2,
    FS_LOW_XFER = 3'd3,
    FS_HI_XFER  = 3'd4,
    FS_TOGGLE   = 3'd5,
    FS_RSV6     = 3'd6,
    FS_RSV7     = 3'd7
  } fs_mode_e;
endpackage

// File: rtl/fsync_pulse_timer.sv
module fsync_pulse_timer #(
  parameter int unsigned LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             active_o,
  output logic             last_o
);
  logic [LEN_W-1:0] cnt_q;
  logic             active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (start_i) begin
      cnt_q    <= '0;
      active_q <= 1'b1;
    end else if (active_q) begin
      if (cnt_q == len_i) active_q <= 1'b0;
      else                cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign active_o = active_q;
  // restart beats end of window
  assign last_o   = active_q && (cnt_q == len_i) && !start_i;
endmodule

// File: rtl/fsync_shape.sv
module fsync_shape
  import rx_fsync_pkg::*;
(
  input  fs_mode_e mode_i,
  input  logic     active_i,
  input  logic     xfer_i,
  input  logic     tog_i,
  output logic     fs_o,
  output logic     oe_o
);
  always_comb begin
    fs_o = 1'b0;
    oe_o = 1'b1;
    unique case (mode_i)
      FS_NEG:      fs_o = !active_i;
      FS_POS:      fs_o = active_i;
      FS_LOW_XFER: fs_o = !xfer_i;
      FS_HI_XFER:  fs_o = xfer_i;
      FS_TOGGLE:   fs_o = tog_i;
      default:     oe_o = 1'b0; // off and reserved: pin released
    endcase
  end
endmodule

// File: rtl/fsync_edge_mon.sv
module fsync_edge_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic edge_sel_i,
  input  logic clr_i,
  output logic det_o
);
  logic line_q, vld_q, det_q, hit;

  assign hit = vld_q && (edge_sel_i ? (line_q && !line_i) : (!line_q && line_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= 1'b0;
      vld_q  <= 1'b0;
      det_q  <= 1'b0;
    end else begin
      line_q <= line_i;
      vld_q  <= 1'b1;
      if (hit)        det_q <= 1'b1;
      else if (clr_i) det_q <= 1'b0;
    end
  end

  assign det_o = det_q;
endmodule

// File: rtl/fsync_capture.sv
module fsync_capture #(
  parameter int unsigned LEN_W = 8,
  parameter int unsigned SD_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             active_i,
  input  logic             last_i,
  input  logic             sd_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             cmp_en_i,
  input  logic [SD_W-1:0]  pat0_i,
  input  logic [SD_W-1:0]  pat1_i,
  output logic [SD_W-1:0]  data_o,
  output logic             match_o
);
  localparam int unsigned N_W = LEN_W + 1;

  logic [SD_W-2:0] sh_q;
  logic [SD_W-1:0] shifted, mask, data_q;
  logic [N_W-1:0]  nbits;
  logic            match_q, hit;

  assign shifted = {sh_q, sd_i};
  assign nbits   = {1'b0, len_i} + N_W'(1);

  for (genvar i = 0; i < SD_W; i++) begin : g_mask
    assign mask[i] = (nbits > N_W'(i));
  end

  assign hit = ((shifted & mask) == (pat0_i & mask)) ||
               ((shifted & mask) == (pat1_i & mask));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      data_q  <= '0;
      match_q <= 1'b0;
    end else begin
      if (start_i)       sh_q <= '0;
      else if (active_i) sh_q <= shifted[SD_W-2:0];
      if (last_i) begin
        data_q  <= shifted;
        match_q <= cmp_en_i && hit;
      end else begin
        match_q <= 1'b0;
      end
    end
  end

  assign data_o  = data_q;
  assign match_o = match_q;
endmodule

// File: rtl/rx_fsync_gen.sv
module rx_fsync_gen
  import rx_fsync_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  xfer_active_i,
  input  logic [2:0]            mode_i,
  input  logic [LEN_HALF_W-1:0] len_hi_i,
  input  logic [LEN_HALF_W-1:0] len_lo_i,
  input  logic                  edge_sel_i,
  input  logic                  flag_clr_i,
  input  logic                  sd_i,
  input  logic                  fs_pin_i,
  input  logic                  cmp_en_i,
  input  logic [SD_W-1:0]       cmp_pat0_i,
  input  logic [SD_W-1:0]       cmp_pat1_i,
  output logic                  fs_o,
  output logic                  fs_oe_o,
  output logic                  sync_det_o,
  output logic [SD_W-1:0]       sync_data_o,
  output logic                  match_o
);
  logic [LEN_W-1:0] len;
  logic             active, last, tog_q, fs_int, oe_int, mon_line;

  assign len = {len_hi_i, len_lo_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      tog_q <= 1'b0;
    else if (start_i) tog_q <= !tog_q;
  end

  fsync_pulse_timer #(.LEN_W(LEN_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .len_i   (len),
    .active_o(active),
    .last_o  (last)
  );

  fsync_shape u_shape (
    .mode_i  (fs_mode_e'(mode_i)),
    .active_i(active),
    .xfer_i  (xfer_active_i),
    .tog_i   (tog_q),
    .fs_o    (fs_int),
    .oe_o    (oe_int)
  );

  assign mon_line = oe_int ? fs_int : fs_pin_i;

  fsync_edge_mon u_mon (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .line_i    (mon_line),
    .edge_sel_i(edge_sel_i),
    .clr_i     (flag_clr_i),
    .det_o     (sync_det_o)
  );

  fsync_capture #(.LEN_W(LEN_W), .SD_W(SD_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .active_i(active),
    .last_i  (last),
    .sd_i    (sd_i),
    .len_i   (len),
    .cmp_en_i(cmp_en_i),
    .pat0_i  (cmp_pat0_i),
    .pat1_i  (cmp_pat1_i),
    .data_o  (sync_data_o),
    .match_o (match_o)
  );

  assign fs_o    = fs_int;
  assign fs_oe_o = oe_int;
endmodule

// File: rtl/rx_fsync_gen_chk.sv
module rx_fsync_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic [2:0] mode_i,
  input logic [3:0] len_hi_i,
  input logic [3:0] len_lo_i,
  input logic       flag_clr_i,
  input logic       cmp_en_i,
  input logic       fs_o,
  input logic       fs_oe_o,
  input logic       sync_det_o,
  input logic       match_o
);
  logic       past_vld;
  logic [8:0] since_q;
  logic [8:0] win_len;

  assign win_len = {1'b0, len_hi_i, len_lo_i} + 9'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      past_vld <= 1'b0;
      since_q  <= '0;
    end else begin
      past_vld <= 1'b1;
      if (start_i)               since_q <= 9'd1;
      else if (since_q != '1)    since_q <= since_q + 9'd1;
    end
  end

  p_pulse_len_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd2 && fs_o) |-> (since_q >= 9'd1 && since_q <= win_len));

  p_toggle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_vld && $past(start_i) && mode_i == 3'd5 && $past(mode_i) == 3'd5)
      |-> (fs_o != $past(fs_o)));

  p_released_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd0 || mode_i == 3'd6 || mode_i == 3'd7) |-> (!fs_oe_o && !fs_o));

  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_vld && $past(sync_det_o) && !$past(flag_clr_i)) |-> sync_det_o);

  p_match_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_o |=> !match_o);

  p_match_enabled_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_vld && match_o) |-> $past(cmp_en_i));
endmodule

bind rx_fsync_gen rx_fsync_gen_chk u_chk (.*);

// File: tb/rx_fsync_gen_tb_top.sv
module rx_fsync_gen_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, xfer_active_i = 1'b0;
  logic [2:0]  mode_i = 3'd0;
  logic [3:0]  len_hi_i = '0, len_lo_i = '0;
  logic        edge_sel_i = 1'b0, flag_clr_i = 1'b0, sd_i = 1'b0, fs_pin_i = 1'b0;
  logic        cmp_en_i = 1'b0;
  logic [15:0] cmp_pat0_i = '0, cmp_pat1_i = '0;
  logic        fs_o, fs_oe_o, sync_det_o, match_o;
  logic [15:0] sync_data_o;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk_i = !clk_i;

  rx_fsync_gen dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic sbit(input int seed, input int c);
    logic [31:0] h;
    h = (seed * 32'd2654435761) ^ (c * 32'd40503) ^ (c << 9);
    return h[7] ^ h[3] ^ h[12] ^ h[17];
  endfunction

  function automatic logic [15:0] exp_word(input int seed, input int first, input int last);
    logic [15:0] w = '0;
    for (int c = first; c <= last; c++) w = {w[14:0], sbit(seed, c)};
    return w;
  endfunction

  task automatic set_len(input int l);
    len_hi_i = 4'(l >> 4);
    len_lo_i = 4'(l);
  endtask

  task automatic settle(input int m, input int l, input logic es);
    @(negedge clk_i);
    mode_i = 3'(m); set_len(l); edge_sel_i = es; flag_clr_i = 1'b1; start_i = 1'b0;
    repeat (3) @(negedge clk_i);
  endtask

  // one window in mode 1 or 2; variant picks the compare setup
  task automatic run_win(input int m, input int l, input logic es, input int variant, input int seed);
    int n = l + 1;
    logic [15:0] exp, mask;
    logic exp_match;
    exp  = exp_word(seed, 1, n);
    mask = (n >= 16) ? 16'hFFFF : 16'((1 << n) - 1);
    settle(m, l, es);
    case (variant)
      0: begin cmp_en_i = 1; cmp_pat0_i = exp | ~mask; cmp_pat1_i = ~exp; exp_match = 1; end
      1: begin cmp_en_i = 1; cmp_pat0_i = exp ^ 16'h1; cmp_pat1_i = exp; exp_match = 1; end
      2: begin cmp_en_i = 1; cmp_pat0_i = exp ^ 16'h1; cmp_pat1_i = exp ^ 16'h1; exp_match = 0; end
      default: begin cmp_en_i = 0; cmp_pat0_i = exp; cmp_pat1_i = exp; exp_match = 0; end
    endcase
    flag_clr_i = 1'b0; start_i = 1'b1; sd_i = 1'b0;
    for (int c = 1; c <= n + 2; c++) begin
      @(negedge clk_i);
      chk((m == 2) ? "R3 window high" : "R2 window low", fs_o,
          (m == 2) ? (c <= n) : !(c <= n));
      if (c == 1) chk("R1 oe", fs_oe_o, 1);
      if (c == 2) chk("R7 edge select", sync_det_o, ((m == 2) == (es == 0)));
      if (c == n + 1) begin
        chk("R9 sync data", sync_data_o, exp);
        chk("R10 match", match_o, exp_match);
      end
      if (c == n + 2) begin
        chk("R10 one-cycle match", match_o, 0);
        chk("R8 sticky flag", sync_det_o, 1);
      end
      start_i = 1'b0;
      sd_i = sbit(seed, c);
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 150000) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic b;
    // reset with a driven idle-high line: no spurious edge (R7)
    mode_i = 3'd1; edge_sel_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R2 reset idle high", fs_o, 1);
    chk("R9 reset data", sync_data_o, 0);
    chk("R10 reset match", match_o, 0);
    chk("R8 reset flag", sync_det_o, 0);
    repeat (2) @(negedge clk_i);
    chk("R7 no edge after reset", sync_det_o, 0);

    // R1 R2 R3 R9 R10: length sweep, both halves of L
    for (int l = 0; l <= 20; l++)
      run_win((l % 2) ? 1 : 2, l, 1'((l / 2) % 2), l % 4, l + 3);
    run_win(2, 31, 0, 0, 91);
    run_win(1, 47, 1, 1, 92);
    run_win(2, 100, 1, 2, 93);
    run_win(1, 255, 0, 3, 94);

    // R11: restart mid-window, L=4
    settle(2, 4, 0);
    cmp_en_i = 1; cmp_pat0_i = exp_word(77, 3, 7); cmp_pat1_i = ~exp_word(77, 3, 7);
    flag_clr_i = 0; start_i = 1; sd_i = 0;
    for (int c = 1; c <= 9; c++) begin
      @(negedge clk_i);
      chk("R11 restart window", fs_o, (c <= 7));
      if (c == 8) begin
        chk("R11 restart data", sync_data_o, exp_word(77, 3, 7));
        chk("R11 restart match", match_o, 1);
      end
      start_i = (c == 2);
      sd_i = sbit(77, c);
    end

    // R8: edge in a clear cycle wins, lone clear clears
    settle(2, 3, 0);
    flag_clr_i = 0; start_i = 1;
    @(negedge clk_i); start_i = 0; flag_clr_i = 1;      // cycle with rising edge
    @(negedge clk_i); chk("R8 edge beats clear", sync_det_o, 1);
    @(negedge clk_i); chk("R8 clear", sync_det_o, 0); flag_clr_i = 0;
    repeat (4) @(negedge clk_i);
    chk("R8 stays clear (falling not selected)", sync_det_o, 0);

    // R4: level modes follow the transfer-active level
    for (int m = 3; m <= 4; m++)
      for (int x = 0; x <= 1; x++) begin
        @(negedge clk_i); mode_i = 3'(m); xfer_active_i = 1'(x);
        #1;
        chk("R4 level mode", fs_o, (m == 3) ? !x : x);
        chk("R4 level oe", fs_oe_o, 1);
      end
    xfer_active_i = 0;

    // R5: toggle mode
    @(negedge clk_i); mode_i = 3'd5;
    @(negedge clk_i); b = fs_o; start_i = 1;
    @(negedge clk_i); chk("R5 toggle on start", fs_o, !b); start_i = 0;
    repeat (2) @(negedge clk_i);
    chk("R5 hold without start", fs_o, !b);
    start_i = 1;
    @(negedge clk_i); chk("R5 toggle back", fs_o, b); start_i = 0;

    // R6: released modes, with starts running
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i); mode_i = (k == 0) ? 3'd0 : 3'(5 + k); start_i = 1;
      for (int c = 0; c < 3; c++) begin
        @(negedge clk_i);
        chk("R6 released oe", fs_oe_o, 0);
        chk("R6 released value", fs_o, 0);
        start_i = 0;
      end
    end

    // R7: pin input monitored when released
    settle(0, 0, 0);
    fs_pin_i = 0; flag_clr_i = 0;
    @(negedge clk_i); fs_pin_i = 1;
    @(negedge clk_i); chk("R7 pin rise seen", sync_det_o, 1);
    edge_sel_i = 1; flag_clr_i = 1;
    @(negedge clk_i); flag_clr_i = 0;
    @(negedge clk_i); chk("R7 flag cleared", sync_det_o, 0); fs_pin_i = 0;
    @(negedge clk_i); chk("R7 pin fall seen", sync_det_o, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule